// File: doc/BRIEF.md
# Instruction Fetch Accelerator Cache

This block is a small read-only cache placed in front of the code memory path of a secondary processor. The processor presents one access at a time on a 32-bit request port. A read that is flagged both as an instruction fetch and as cacheable is looked up in a direct-mapped store of 64 lines, each 256 bits wide. A hit returns the addressed 32-bit word in the next cycle. A miss starts a line refill over a 64-bit wide downstream port: four beats are gathered in a 256-bit line buffer, written into the store, and the requested word is returned.

Every other access (data reads, writes, and fetches not marked cacheable) is passed unchanged to a separate 32-bit bypass port, and its reply is handed back to the requester. Such accesses never read or change the cache. A flush input lets software drop all cached lines after code memory has been rewritten.

The control is one state machine with five states. `ST_IDLE` accepts a request; a hit stays in `ST_IDLE`, a miss goes to `ST_FILL_ADDR`, and a non-cached access goes to `ST_BYP_ADDR`. `ST_FILL_ADDR` goes to `ST_FILL_DATA` when the wide port acknowledges. `ST_FILL_DATA` goes back to `ST_IDLE` on the fourth beat. `ST_BYP_ADDR` goes to `ST_BYP_WAIT` when the bypass port grants. `ST_BYP_WAIT` goes back to `ST_IDLE` when the bypass reply arrives.

Top module: `ifc_cache`

## Requirements
- R1: An access uses the cache only when `up_instr`=1, `up_cacheable`=1 and `up_write`=0. Any other access is forwarded on the bypass port with the same address, write flag and write data. Its reply data and error flag are returned on the upstream response one cycle after `byp_rsp_valid`.
- R2: The store is direct-mapped with 64 lines of 256 bits. The line index is address bits [10:5], the tag is bits [31:11], and bits [4:2] select the 32-bit word within the line.
- R3: A cacheable fetch that hits raises `up_rsp_valid` in the cycle after acceptance, with the addressed word and `up_rsp_err`=0. It makes no request on either downstream port.
- R4: A miss raises `fill_req` with a line-aligned `fill_addr` (bits [4:0] zero) and holds both until `fill_ack`. It then accepts four `fill_beat_valid` beats. Beat k carries line bytes 8k to 8k+7, with the lower address in bits [31:0]. The response comes one cycle after the fourth beat and carries the requested word.
- R5: After a clean refill, later fetches to the same line hit. A fetch whose tag differs but whose index is the same misses and replaces the line.
- R6: A `flush` pulse clears every valid bit in one cycle. A cacheable fetch accepted in the same cycle as `flush` is treated as a miss.
- R7: A flush that arrives while a refill is in progress does not disturb that refill's response. The refilled line is still left invalid.
- R8: If any refill beat has `fill_beat_err`=1, the response after the fourth beat has `up_rsp_err`=1 and data zero, and the line is left invalid.
- R9: Only one access is in flight at a time. `up_gnt` is high only in the idle state, and `fill_req` and `byp_req` are never high together.
- R10: After reset, `up_gnt`=1 and `up_rsp_valid`, `fill_req` and `byp_req` are 0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all lines |
| up_req | input | 1 | Upstream request |
| up_gnt | output | 1 | Request accepted at this edge |
| up_addr | input | 32 | Byte address |
| up_write | input | 1 | Write access |
| up_wdata | input | 32 | Write data |
| up_instr | input | 1 | Instruction fetch flag |
| up_cacheable | input | 1 | Cacheable flag |
| up_rsp_valid | output | 1 | Response strobe |
| up_rdata | output | 32 | Response data |
| up_rsp_err | output | 1 | Response error |
| byp_req | output | 1 | Bypass request |
| byp_gnt | input | 1 | Bypass request accepted |
| byp_addr | output | 32 | Bypass address |
| byp_write | output | 1 | Bypass write flag |
| byp_wdata | output | 32 | Bypass write data |
| byp_rsp_valid | input | 1 | Bypass reply strobe |
| byp_rdata | input | 32 | Bypass reply data |
| byp_rsp_err | input | 1 | Bypass reply error |
| fill_req | output | 1 | Refill burst request |
| fill_ack | input | 1 | Refill burst accepted |
| fill_addr | output | 32 | Line-aligned refill address |
| fill_beat_valid | input | 1 | Refill beat strobe |
| fill_beat_data | input | 64 | Refill beat data |
| fill_beat_err | input | 1 | Refill beat error |

## Verification
The assertions check several properties on every cycle: a hit answers one cycle after acceptance; an accepted non-cached access requests the bypass port next; a miss requests a refill next; the refill request and address stay stable until acknowledged; the two downstream requests never overlap; and a failed refill ends in an error response. Some behaviours need whole sequences, so only the bench scenarios can show them. These are that a refilled line really produces later hits, that a conflicting tag evicts it, that a flush (alone, in the same cycle as a fetch, or during a refill) forces a later miss, and that a refill error leaves the line invalid. Word selection at the last line index is also covered there.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_ADDR,
        ST_FILL_DATA,
        ST_BYP_ADDR,
        ST_BYP_WAIT
    } ifc_state_e;
endpackage

// File: rtl/ifc_tag_store.sv
module ifc_tag_store #(
    parameter int LINES = 64,
    parameter int TAG_W = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     set_en,
    input  logic                     clr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic                     rd_valid,
    output logic [TAG_W-1:0]         rd_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_mem [LINES];

    // flush wins over any single-line update in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (set_en) begin
            valid_q[wr_idx] <= 1'b1;
        end else if (clr_en) begin
            valid_q[wr_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/ifc_line_store.sv
module ifc_line_store #(
    parameter int LINES  = 64,
    parameter int LINE_W = 256
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [LINE_W-1:0]        wr_line,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic [LINE_W-1:0]        rd_line
);
    logic [LINE_W-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_line;
        end
    end

    assign rd_line = mem[rd_idx];
endmodule

// File: rtl/ifc_line_buf.sv
module ifc_line_buf #(
    parameter int LINE_W = 256,
    parameter int WIDE_W = 64
) (
    input  logic                                clk,
    input  logic                                beat_en,
    input  logic [$clog2(LINE_W/WIDE_W)-1:0]    beat_idx,
    input  logic [WIDE_W-1:0]                   beat_data,
    output logic [LINE_W-1:0]                   line_next
);
    localparam int BEATS  = LINE_W / WIDE_W;
    localparam int BEAT_W = $clog2(BEATS);

    // each slice captures its beat; line_next already holds the beat arriving now
    for (genvar b = 0; b < BEATS; b++) begin : g_slice
        logic [WIDE_W-1:0] slice_q;
        logic              hit_here;

        assign hit_here = beat_en && (beat_idx == BEAT_W'(b));

        always_ff @(posedge clk) begin
            if (hit_here) begin
                slice_q <= beat_data;
            end
        end

        assign line_next[b*WIDE_W +: WIDE_W] = hit_here ? beat_data : slice_q;
    end
endmodule

// File: rtl/ifc_cache.sv
module ifc_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WIDE_W = 64,
    parameter int LINES  = 64,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              up_req,
    output logic              up_gnt,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_write,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic              up_instr,
    input  logic              up_cacheable,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_rsp_err,
    output logic              byp_req,
    input  logic              byp_gnt,
    output logic [ADDR_W-1:0] byp_addr,
    output logic              byp_write,
    output logic [DATA_W-1:0] byp_wdata,
    input  logic              byp_rsp_valid,
    input  logic [DATA_W-1:0] byp_rdata,
    input  logic              byp_rsp_err,
    output logic              fill_req,
    input  logic              fill_ack,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_beat_valid,
    input  logic [WIDE_W-1:0] fill_beat_data,
    input  logic              fill_beat_err
);
    import ifc_pkg::*;

    localparam int OFF_W   = $clog2(LINE_W / 8);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int BEATS   = LINE_W / WIDE_W;
    localparam int BEAT_W  = $clog2(BEATS);
    localparam int WSEL_W  = $clog2(LINE_W / DATA_W);
    localparam int DBYTE_W = $clog2(DATA_W / 8);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    ifc_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BEAT_W-1:0] beat_q;
    logic              err_seen_q;
    logic              flush_pend_q;
    logic              rsp_valid_q;
    logic              rsp_err_q;
    logic [DATA_W-1:0] rsp_data_q;

    // lookup on the live request address
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic [WSEL_W-1:0] lk_word;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;
    logic [DATA_W-1:0] hit_word;
    logic              lookup_hit;
    logic              cache_access;
    logic              accept;

    // refill datapath
    logic [IDX_W-1:0]  fl_idx;
    logic [TAG_W-1:0]  fl_tag;
    logic [WSEL_W-1:0] fl_word;
    logic              beat_en;
    logic              fill_last;
    logic              fill_bad;
    logic              line_set;
    logic              line_clr;
    logic [LINE_W-1:0] line_next;
    logic [DATA_W-1:0] fill_word;

    assign lk_idx  = up_addr[OFF_W +: IDX_W];
    assign lk_tag  = up_addr[ADDR_W-1 -: TAG_W];
    assign lk_word = up_addr[DBYTE_W +: WSEL_W];
    assign fl_idx  = addr_q[OFF_W +: IDX_W];
    assign fl_tag  = addr_q[ADDR_W-1 -: TAG_W];
    assign fl_word = addr_q[DBYTE_W +: WSEL_W];

    assign cache_access = up_instr && up_cacheable && !up_write;
    assign accept       = up_req && (state_q == ST_IDLE);
    assign lookup_hit   = rd_valid && (rd_tag == lk_tag) && !flush;
    assign hit_word     = rd_line[lk_word*DATA_W +: DATA_W];

    assign beat_en   = (state_q == ST_FILL_DATA) && fill_beat_valid;
    assign fill_last = beat_en && (beat_q == LAST_BEAT);
    assign fill_bad  = err_seen_q || fill_beat_err;
    assign line_set  = fill_last && !fill_bad && !flush_pend_q && !flush;
    assign line_clr  = fill_last && fill_bad;
    assign fill_word = line_next[fl_word*DATA_W +: DATA_W];

    ifc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .set_en   (line_set),
        .clr_en   (line_clr),
        .wr_idx   (fl_idx),
        .wr_tag   (fl_tag),
        .rd_idx   (lk_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag)
    );

    ifc_line_store #(.LINES(LINES), .LINE_W(LINE_W)) u_lines (
        .clk     (clk),
        .wr_en   (line_set),
        .wr_idx  (fl_idx),
        .wr_line (line_next),
        .rd_idx  (lk_idx),
        .rd_line (rd_line)
    );

    ifc_line_buf #(.LINE_W(LINE_W), .WIDE_W(WIDE_W)) u_lbuf (
        .clk       (clk),
        .beat_en   (beat_en),
        .beat_idx  (beat_q),
        .beat_data (fill_beat_data),
        .line_next (line_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!cache_access)    state_d = ST_BYP_ADDR;
                    else if (!lookup_hit) state_d = ST_FILL_ADDR;
                end
            end
            ST_FILL_ADDR: if (fill_ack)      state_d = ST_FILL_DATA;
            ST_FILL_DATA: if (fill_last)     state_d = ST_IDLE;
            ST_BYP_ADDR:  if (byp_gnt)       state_d = ST_BYP_WAIT;
            ST_BYP_WAIT:  if (byp_rsp_valid) state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        up_gnt   = 1'b0;
        fill_req = 1'b0;
        byp_req  = 1'b0;
        unique case (state_q)
            ST_IDLE:      up_gnt   = 1'b1;
            ST_FILL_ADDR: fill_req = 1'b1;
            ST_FILL_DATA: ;
            ST_BYP_ADDR:  byp_req  = 1'b1;
            ST_BYP_WAIT:  ;
        endcase
    end

    // request capture, beat counting and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q       <= '0;
            write_q      <= 1'b0;
            wdata_q      <= '0;
            beat_q       <= '0;
            err_seen_q   <= 1'b0;
            flush_pend_q <= 1'b0;
            rsp_valid_q  <= 1'b0;
            rsp_err_q    <= 1'b0;
            rsp_data_q   <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept) begin
                addr_q       <= up_addr;
                write_q      <= up_write;
                wdata_q      <= up_wdata;
                beat_q       <= '0;
                err_seen_q   <= 1'b0;
                flush_pend_q <= 1'b0;
                if (cache_access && lookup_hit) begin
                    rsp_valid_q <= 1'b1;
                    rsp_err_q   <= 1'b0;
                    rsp_data_q  <= hit_word;
                end
            end
            if (flush && (state_q == ST_FILL_ADDR || state_q == ST_FILL_DATA)) begin
                flush_pend_q <= 1'b1;
            end
            if (beat_en) begin
                beat_q <= beat_q + 1'b1;
                if (fill_beat_err) err_seen_q <= 1'b1;
            end
            if (fill_last) begin
                rsp_valid_q <= 1'b1;
                rsp_err_q   <= fill_bad;
                rsp_data_q  <= fill_bad ? '0 : fill_word;
            end
            if (state_q == ST_BYP_WAIT && byp_rsp_valid) begin
                rsp_valid_q <= 1'b1;
                rsp_err_q   <= byp_rsp_err;
                rsp_data_q  <= byp_rdata;
            end
        end
    end

    assign up_rsp_valid = rsp_valid_q;
    assign up_rdata     = rsp_data_q;
    assign up_rsp_err   = rsp_err_q;
    assign fill_addr    = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign byp_addr     = addr_q;
    assign byp_write    = write_q;
    assign byp_wdata    = wdata_q;

    // ---------------- assertions ----------------
    assert_route_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cache_access |=> byp_req && !fill_req);

    assert_hit_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cache_access && lookup_hit |=> up_rsp_valid && !up_rsp_err && !fill_req && !byp_req);

    assert_miss_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cache_access && !lookup_hit |=> fill_req);

    assert_fill_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req && !fill_ack |=> fill_req && $stable(fill_addr));

    assert_flush_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cache_access && flush |=> !up_rsp_valid);

    assert_err_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_last && fill_bad |=> up_rsp_valid && up_rsp_err && (up_rdata == '0));

    assert_one_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_req && byp_req) && !(up_gnt && (fill_req || byp_req)));
endmodule

// File: tb/ifc_cache_bench.sv
module ifc_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BAD_ADDR = 32'h0BAD_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        up_req = 1'b0;
    logic        up_gnt;
    logic [31:0] up_addr = '0;
    logic        up_write = 1'b0;
    logic [31:0] up_wdata = '0;
    logic        up_instr = 1'b0;
    logic        up_cacheable = 1'b0;
    logic        up_rsp_valid;
    logic [31:0] up_rdata;
    logic        up_rsp_err;
    logic        byp_req;
    logic        byp_gnt = 1'b0;
    logic [31:0] byp_addr;
    logic        byp_write;
    logic [31:0] byp_wdata;
    logic        byp_rsp_valid = 1'b0;
    logic [31:0] byp_rdata = '0;
    logic        byp_rsp_err = 1'b0;
    logic        fill_req;
    logic        fill_ack = 1'b0;
    logic [31:0] fill_addr;
    logic        fill_beat_valid = 1'b0;
    logic [63:0] fill_beat_data = '0;
    logic        fill_beat_err = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    int fill_cnt = 0;
    int byp_cnt  = 0;
    int err_beat = -1;
    bit done     = 1'b0;
    logic [31:0] byp_seen_addr, byp_seen_wdata;
    logic        byp_seen_write;

    logic [32:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ifc_cache u_ifc_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .up_req(up_req), .up_gnt(up_gnt), .up_addr(up_addr), .up_write(up_write),
        .up_wdata(up_wdata), .up_instr(up_instr), .up_cacheable(up_cacheable),
        .up_rsp_valid(up_rsp_valid), .up_rdata(up_rdata), .up_rsp_err(up_rsp_err),
        .byp_req(byp_req), .byp_gnt(byp_gnt), .byp_addr(byp_addr), .byp_write(byp_write),
        .byp_wdata(byp_wdata), .byp_rsp_valid(byp_rsp_valid), .byp_rdata(byp_rdata),
        .byp_rsp_err(byp_rsp_err), .fill_req(fill_req), .fill_ack(fill_ack),
        .fill_addr(fill_addr), .fill_beat_valid(fill_beat_valid),
        .fill_beat_data(fill_beat_data), .fill_beat_err(fill_beat_err)
    );

    function automatic logic [31:0] mw(input logic [31:0] a);
        return ((a & ~32'h3) * 32'h9E37_79B1) ^ 32'h1357_9BDF;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // wide refill port model (R4 ordering: beat k = line bytes 8k..8k+7)
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req) begin
                logic [31:0] base;
                base = fill_addr;
                fill_cnt++;
                chk(base[4:0] == 5'd0, "R4", "fill address aligned", base, base & ~32'h1F);
                fill_ack = 1'b1;
                @(negedge clk);
                fill_ack = 1'b0;
                for (int b = 0; b < 4; b++) begin
                    logic [31:0] lo;
                    lo = base + 32'(8*b);
                    fill_beat_valid = 1'b1;
                    fill_beat_data  = {mw(lo + 32'd4), mw(lo)};
                    fill_beat_err   = (b == err_beat);
                    @(negedge clk);
                end
                fill_beat_valid = 1'b0;
                fill_beat_err   = 1'b0;
            end
        end
    end

    // bypass port model: reply data is the inverted address
    initial begin
        forever begin
            @(negedge clk);
            if (byp_req) begin
                byp_cnt++;
                byp_seen_addr  = byp_addr;
                byp_seen_write = byp_write;
                byp_seen_wdata = byp_wdata;
                byp_gnt = 1'b1;
                @(negedge clk);
                byp_gnt = 1'b0;
                @(negedge clk);
                byp_rsp_valid = 1'b1;
                byp_rdata     = ~byp_seen_addr;
                byp_rsp_err   = (byp_seen_addr == BAD_ADDR);
                @(negedge clk);
                byp_rsp_valid = 1'b0;
                byp_rsp_err   = 1'b0;
            end
        end
    end

    // monitor: pops the scoreboard on each response
    initial begin
        forever begin
            @(negedge clk);
            if (up_rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected response", up_rdata, 32'h0);
                end else begin
                    logic [32:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(up_rdata == e[31:0], t, "response data", up_rdata, e[31:0]);
                    chk(up_rsp_err == e[32], t, "response error", 32'(up_rsp_err), 32'(e[32]));
                end
            end
        end
    end

    // driver: issues one access and pushes its expected reply
    task automatic access(input logic [31:0] a, input logic instr, input logic cach,
                          input logic wr, input logic [31:0] wd,
                          input logic [31:0] exp_d, input logic exp_e,
                          input bit exp_hit, input string req);
        int f0, b0;
        @(negedge clk);
        up_req = 1'b1; up_addr = a; up_instr = instr; up_cacheable = cach;
        up_write = wr; up_wdata = wd;
        while (!up_gnt) @(negedge clk);
        f0 = fill_cnt; b0 = byp_cnt;
        exp_q.push_back({exp_e, exp_d});
        tag_q.push_back(req);
        @(negedge clk);
        up_req = 1'b0;
        if (exp_hit) begin
            chk(up_rsp_valid == 1'b1, req, "hit answered next cycle", 32'(up_rsp_valid), 32'd1);
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        if (exp_hit) begin
            chk(fill_cnt == f0 && byp_cnt == b0, req, "hit made no downstream request",
                32'(fill_cnt - f0 + byp_cnt - b0), 32'd0);
        end
    endtask

    task automatic expect_fills(input int exp, input string req);
        chk(fill_cnt == exp, req, "refill count", 32'(fill_cnt), 32'(exp));
    endtask

    initial begin
        logic [31:0] a, c, b, d, e;
        a = 32'h0000_1004;   // index 0
        c = 32'h0000_1804;   // index 0, other tag
        b = 32'h0000_2040;   // index 2
        d = 32'h0000_3080;   // index 4
        e = 32'h0000_07FC;   // index 63, word 7

        repeat (3) @(negedge clk);
        chk(up_gnt == 1'b1, "R10", "reset up_gnt", 32'(up_gnt), 32'd1);
        chk(up_rsp_valid == 1'b0 && fill_req == 1'b0 && byp_req == 1'b0, "R10",
            "reset outputs idle", {29'd0, up_rsp_valid, fill_req, byp_req}, 32'd0);
        rst_n = 1'b1;

        // R3 R4 R5: miss then hit in the same line
        access(a, 1, 1, 0, 0, mw(a), 0, 0, "R4");
        expect_fills(1, "R4");
        access(a + 32'h18, 1, 1, 0, 0, mw(a + 32'h18), 0, 1, "R3");
        expect_fills(1, "R5");

        // R2 R5: same index, different tag evicts
        access(c, 1, 1, 0, 0, mw(c), 0, 0, "R2");
        expect_fills(2, "R5");
        access(a, 1, 1, 0, 0, mw(a), 0, 0, "R5");
        expect_fills(3, "R2");

        // R2: last index, last word
        access(e, 1, 1, 0, 0, mw(e), 0, 0, "R2");
        access(e - 32'h1C, 1, 1, 0, 0, mw(e - 32'h1C), 0, 1, "R2");
        expect_fills(4, "R2");

        // R1: non-cacheable fetch, data read, write, error reply
        access(a, 1, 0, 0, 0, ~a, 0, 0, "R1");
        chk(byp_seen_addr == a, "R1", "bypass address", byp_seen_addr, a);
        access(a + 32'h8, 0, 1, 0, 0, ~(a + 32'h8), 0, 0, "R1");
        access(32'h0000_5000, 1, 1, 1, 32'hCAFE_F00D, ~32'h0000_5000, 0, 0, "R1");
        chk(byp_seen_write == 1'b1 && byp_seen_wdata == 32'hCAFE_F00D, "R1",
            "bypass write forwarded", byp_seen_wdata, 32'hCAFE_F00D);
        access(BAD_ADDR, 0, 0, 0, 0, ~BAD_ADDR, 1, 0, "R1");
        chk(byp_cnt == 4, "R1", "bypass count", 32'(byp_cnt), 32'd4);
        expect_fills(4, "R1");
        access(a, 1, 1, 0, 0, mw(a), 0, 1, "R1");

        // R6: plain flush, then a miss
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        access(a, 1, 1, 0, 0, mw(a), 0, 0, "R6");
        expect_fills(5, "R6");
        access(a, 1, 1, 0, 0, mw(a), 0, 1, "R6");

        // R6: flush in the same cycle as the fetch
        fork
            access(a, 1, 1, 0, 0, mw(a), 0, 0, "R6");
            begin @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0; end
        join
        expect_fills(6, "R6");

        // R7: flush during a refill
        fork
            access(b + 32'h4, 1, 1, 0, 0, mw(b + 32'h4), 0, 0, "R7");
            begin
                @(posedge fill_beat_valid);
                @(negedge clk); flush = 1'b1;
                @(negedge clk); flush = 1'b0;
            end
        join
        expect_fills(7, "R7");
        access(b, 1, 1, 0, 0, mw(b), 0, 0, "R7");
        expect_fills(8, "R7");

        // R8: refill error leaves the line invalid
        err_beat = 2;
        access(d + 32'hC, 1, 1, 0, 0, 32'h0, 1, 0, "R8");
        err_beat = -1;
        access(d + 32'hC, 1, 1, 0, 0, mw(d + 32'hC), 0, 0, "R8");
        expect_fills(10, "R8");

        // R9: nothing left in flight
        chk(exp_q.size() == 0 && up_gnt == 1'b1, "R9", "idle after sequence",
            32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog expired: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule